// File: doc/BRIEF.md
# Operand-Free Stack Execution Core

This block executes a stream of instructions whose only working storage is a small hardware stack inside the core. Each instruction arrives with a valid strobe and carries a 2-bit opcode and an 8-bit address. Two opcodes move data between the stack and an external synchronous data memory. The other two are arithmetic operations that name no operands. They always consume the two topmost entries and leave one result in their place.

A load reads memory through a registered read request. The memory returns its word one cycle later, and the core pushes that word. While a load is in flight the core raises `busy`, and it ignores any strobe it sees during that time. A store takes the top entry and writes it to the given memory address. Arithmetic completes in one cycle. An instruction that would overrun or underrun the stack sets a sticky fault flag and changes nothing else. Program sequencing happens outside the block: whatever drives the instruction port decides the order.

Top module: `stack_core`

## Requirements
- R1: After a synchronous active-high reset, `depth` is 0, and `busy`, `err`, `mem_re` and `mem_we` are 0.
- R2: Opcode 00 (load) on a stack that is not full does three things. It raises `mem_re` with `mem_addr` equal to the address field in the cycle after acceptance. It holds `busy` high for two cycles. It then places the returned word on top and increments `depth` by one.
- R3: Opcode 01 (store) on a non-empty stack raises `mem_we` for one cycle in the cycle after acceptance. It drives the top entry on `mem_wdata` to the address field, and decrements `depth` by one.
- R4: Opcode 10 (add) with at least two entries replaces them with their sum modulo 2^16 and decrements `depth` by one.
- R5: Opcode 11 (subtract) with at least two entries replaces them with (entry below top) minus (top) modulo 2^16 and decrements `depth` by one.
- R6: Entries leave the stack in the reverse order of their arrival.
- R7: A load while `depth` is 8 sets `err` and issues no memory read. It leaves `depth` and every entry unchanged.
- R8: A store with `depth` 0, or an add or subtract with `depth` below 2, sets `err` and issues no memory write. It leaves `depth` and the entries unchanged.
- R9: Once set, `err` stays at 1 until reset, whatever instructions follow.
- R10: Add and subtract ignore the address field and write no memory.
- R11: A valid strobe seen while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe, taken when `busy` is 0 |
| instr_op | input | 2 | Opcode: 00 load, 01 store, 10 add, 11 subtract |
| instr_addr | input | 8 | Memory address for load and store |
| busy | output | 1 | High while a load is in flight |
| err | output | 1 | Sticky overrun/underrun fault |
| depth | output | 4 | Number of entries on the stack (0 to 8) |
| mem_addr | output | 8 | Memory address, registered |
| mem_re | output | 1 | Memory read request, registered |
| mem_we | output | 1 | Memory write enable, registered |
| mem_wdata | output | 16 | Memory write data, registered |
| mem_rdata | input | 16 | Read word, valid the cycle after `mem_re` is sampled |

## Verification
The bench runs the load, load, add, store chain on chosen values to check the basic sum. Wrapping operands show that the sum and difference are taken modulo 2^16. Reversed operand orders show which entry is the subtrahend. A three-deep load and store sequence tells LIFO order apart from FIFO order. Filling the stack and then draining it, starting from empty, checks the fault paths on both edges and shows that faulted instructions leave the contents intact. A long random run of legal instructions at every depth compares each stored word and each depth against a bench model. A strobe injected during a load tells whether `busy` truly holds off acceptance.

// File: rtl/stack_core_pkg.sv
package stack_core_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_SUB   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_CAP  = 2'b10
  } state_e;
endpackage

// File: rtl/stack_core_alu.sv
module stack_core_alu #(
  parameter int WIDTH = 16
) (
  input  logic             sub,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    if (sub) res = lhs - rhs;
    else     res = lhs + rhs;
  end
endmodule

// File: rtl/stack_core_lifo.sv
module stack_core_lifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_en,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_en,
  input  logic             fold_en,
  input  logic [WIDTH-1:0] fold_data,
  output logic [WIDTH-1:0] top,
  output logic [WIDTH-1:0] below,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] ent [DEPTH];
  logic [CW-1:0]    cnt;
  logic [PW-1:0]    top_idx;
  logic [PW-1:0]    below_idx;
  logic [PW-1:0]    push_idx;

  assign top_idx   = PW'(cnt - CW'(1));
  assign below_idx = PW'(cnt - CW'(2));
  assign push_idx  = PW'(cnt);
  assign top       = ent[top_idx];
  assign below     = ent[below_idx];
  assign count     = cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (push_en)      cnt <= cnt + CW'(1);
    else if (pop_en || fold_en) cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_en)      ent[push_idx]  <= push_data;
    else if (fold_en) ent[below_idx] <= fold_data;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R7
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
    push_en |-> cnt < CW'(DEPTH)); // R7
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    push_en |=> cnt == $past(cnt) + CW'(1)); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_en, pop_en, fold_en})); // R6
endmodule

// File: rtl/stack_core.sv
module stack_core
  import stack_core_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [1:0]       instr_op,
  input  logic [AW-1:0]    instr_addr,
  output logic             busy,
  output logic             err,
  output logic [CW-1:0]    depth,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [WIDTH-1:0] mem_wdata,
  input  logic [WIDTH-1:0] mem_rdata
);
  state_e           st;
  op_e              op;
  logic             accept;
  logic             has_one, has_two, is_full;
  logic             load_go, store_go, arith_go, fault;
  logic [WIDTH-1:0] top, below, alu_res;

  assign op      = op_e'(instr_op);
  assign accept  = instr_valid && (st == ST_IDLE);
  assign has_one = depth != '0;
  assign has_two = depth >= CW'(2);
  assign is_full = depth == CW'(DEPTH);

  always_comb begin
    load_go  = 1'b0;
    store_go = 1'b0;
    arith_go = 1'b0;
    fault    = 1'b0;
    if (accept) begin
      case (op)
        OP_LOAD:  if (is_full) fault = 1'b1; else load_go  = 1'b1;
        OP_STORE: if (has_one) store_go = 1'b1; else fault = 1'b1;
        default:  if (has_two) arith_go = 1'b1; else fault = 1'b1;
      endcase
    end
  end

  stack_core_alu #(.WIDTH(WIDTH)) u_alu (
    .sub (op == OP_SUB),
    .lhs (below),
    .rhs (top),
    .res (alu_res)
  );

  stack_core_lifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lifo (
    .clk       (clk),
    .rst       (rst),
    .push_en   (st == ST_CAP),
    .push_data (mem_rdata),
    .pop_en    (store_go),
    .fold_en   (arith_go),
    .fold_data (alu_res),
    .top       (top),
    .below     (below),
    .count     (depth)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      busy      <= 1'b0;
      err       <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      if (fault) err <= 1'b1;
      case (st)
        ST_IDLE: begin
          if (load_go) begin
            mem_re   <= 1'b1;
            mem_addr <= instr_addr;
            busy     <= 1'b1;
            st       <= ST_REQ;
          end else if (store_go) begin
            mem_we    <= 1'b1;
            mem_addr  <= instr_addr;
            mem_wdata <= top;
          end
        end
        ST_REQ:  st <= ST_CAP;
        ST_CAP: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R9
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    load_go |=> busy && mem_re); // R2
  AST_STORE_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    store_go |=> depth == $past(depth) - CW'(1)); // R3
  AST_ARITH_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    arith_go |=> depth == $past(depth) - CW'(1)); // R4
  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fault |=> depth == $past(depth) && !mem_we && !mem_re); // R8
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !mem_we); // R11
endmodule

// File: tb/stack_core_bench.sv
module stack_core_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [1:0]  instr_op = 2'b00;
  logic [7:0]  instr_addr = 8'h00;
  logic        busy, err, mem_re, mem_we;
  logic [3:0]  depth;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        preload = 1'b0;

  logic [15:0] mem     [256];
  logic [15:0] ref_mem [256];
  logic [15:0] ref_stk [8];
  int          ref_cnt;
  logic        ref_err;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  stack_core u_stack_core (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_addr(instr_addr), .busy(busy), .err(err), .depth(depth),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] init_val(input int a);
    if (a == 250) return 16'hFFFF;
    if (a == 251) return 16'h0003;
    return 16'(a * 40503 + 7);
  endfunction

  function automatic logic [15:0] ref_alu(input logic [1:0] op, input logic [15:0] lo, input logic [15:0] hi);
    return (op == 2'b11) ? lo - hi : lo + hi;
  endfunction

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] op, input logic [7:0] a);
    case (op)
      2'b00: if (ref_cnt == 8) ref_err = 1'b1;
             else begin ref_stk[ref_cnt] = ref_mem[a]; ref_cnt++; end
      2'b01: if (ref_cnt == 0) ref_err = 1'b1;
             else begin ref_cnt--; ref_mem[a] = ref_stk[ref_cnt]; end
      default: if (ref_cnt < 2) ref_err = 1'b1;
             else begin
               ref_stk[ref_cnt-2] = ref_alu(op, ref_stk[ref_cnt-2], ref_stk[ref_cnt-1]);
               ref_cnt--;
             end
    endcase
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a, input string tag);
    model(op, a);
    @(negedge clk);
    while (busy) @(negedge clk);
    instr_valid = 1'b1; instr_op = op; instr_addr = a;
    @(negedge clk);
    instr_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk({tag, " depth"}, int'(depth), ref_cnt);
    chk({tag, " err"}, int'(err), int'(ref_err));
    chk({tag, " mem"}, int'(mem[a]), int'(ref_mem[a]));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ref_cnt = 0; ref_err = 1'b0;
    @(negedge clk);
    chk("R1 depth", int'(depth), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 mem_re", int'(mem_re), 0);
    chk("R1 mem_we", int'(mem_we), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) ref_mem[i] = init_val(i);
    preload = 1'b1;
    @(negedge clk);
    preload = 1'b0;
    do_reset();

    // R4: load A, load B, add, store C
    issue(2'b00, 8'd10, "R2"); issue(2'b00, 8'd20, "R2");
    issue(2'b10, 8'd99, "R4"); issue(2'b01, 8'd30, "R3");
    chk("R4 sum", int'(mem[30]), int'(16'(init_val(10) + init_val(20))));
    // R4 wrap
    issue(2'b00, 8'd250, "R2"); issue(2'b00, 8'd251, "R2");
    issue(2'b10, 8'd0, "R4"); issue(2'b01, 8'd31, "R3");
    chk("R4 wrap", int'(mem[31]), 2);
    // R5 order and wrap
    issue(2'b00, 8'd250, "R2"); issue(2'b00, 8'd251, "R2");
    issue(2'b11, 8'd0, "R5"); issue(2'b01, 8'd32, "R3");
    chk("R5 diff", int'(mem[32]), 16'hFFFC);
    issue(2'b00, 8'd251, "R2"); issue(2'b00, 8'd250, "R2");
    issue(2'b11, 8'd0, "R5"); issue(2'b01, 8'd33, "R3");
    chk("R5 wrap", int'(mem[33]), 4);
    // R10: arithmetic address field ignored
    issue(2'b00, 8'd1, "R2"); issue(2'b00, 8'd2, "R2");
    issue(2'b10, 8'd40, "R10");
    chk("R10 untouched", int'(mem[40]), int'(init_val(40)));
    issue(2'b01, 8'd41, "R3");
    // R6: LIFO order
    issue(2'b00, 8'd3, "R6"); issue(2'b00, 8'd4, "R6"); issue(2'b00, 8'd5, "R6");
    issue(2'b01, 8'd50, "R6"); issue(2'b01, 8'd51, "R6"); issue(2'b01, 8'd52, "R6");
    chk("R6 first out", int'(mem[50]), int'(init_val(5)));
    chk("R6 last out", int'(mem[52]), int'(init_val(3)));
    // R11: strobe during busy ignored
    model(2'b00, 8'd6);
    @(negedge clk);
    instr_valid = 1'b1; instr_op = 2'b00; instr_addr = 8'd6;
    @(negedge clk);
    instr_op = 2'b01; instr_addr = 8'd77;
    chk("R11 busy", int'(busy), 1);
    @(negedge clk);
    instr_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R11 depth", int'(depth), ref_cnt);
    chk("R11 mem", int'(mem[77]), int'(ref_mem[77]));
    issue(2'b01, 8'd78, "R11");
    chk("R11 value", int'(mem[78]), int'(init_val(6)));
    // R7: load on full
    for (int i = 0; i < 8; i++) issue(2'b00, 8'(100 + i), "R7");
    issue(2'b00, 8'd120, "R7");
    chk("R7 err", int'(err), 1);
    for (int i = 0; i < 8; i++) issue(2'b01, 8'(130 + i), "R7");
    chk("R7 top kept", int'(mem[130]), int'(init_val(107)));
    // R8, R9: underruns on a fresh core
    do_reset();
    issue(2'b01, 8'd140, "R8");
    chk("R8 store empty err", int'(err), 1);
    do_reset();
    issue(2'b00, 8'd9, "R8");
    issue(2'b10, 8'd0, "R8");
    chk("R8 add short err", int'(err), 1);
    issue(2'b00, 8'd11, "R9");
    issue(2'b01, 8'd141, "R9");
    chk("R9 still set", int'(err), 1);
    issue(2'b01, 8'd142, "R8");
    chk("R8 kept entry", int'(mem[142]), int'(init_val(9)));
    // random legal traffic
    do_reset();
    for (int n = 0; n < 400; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      if (ref_cnt == 0) op = 2'b00;
      else if (ref_cnt == 1 && op[1]) op = 2'($urandom_range(0, 1));
      else if (ref_cnt == 8 && op == 2'b00) op = 2'b01;
      issue(op, 8'($urandom_range(0, 255)), op == 2'b00 ? "R2" : op == 2'b01 ? "R3" : op == 2'b10 ? "R4" : "R5");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule